// File: doc/BRIEF.md
# Keyed-enable watchdog timer

This block is a watchdog that counts ticks of a slow watchdog clock. The tick arrives as a one-cycle enable in the system clock domain. One 8-bit control byte governs it. The top five bits are a key field. The pattern 01010 lets the watchdog count, and the pattern 10101 stops it. Every other pattern is a fault, and the fault leads to a reset. This holds whether a write or a disturbed flop put the pattern there. The low three bits pick the timeout as a power of two of the tick count.

Software keeps the watchdog quiet in one of two ways: it pulses the clear strobe, or it rewrites the control byte. A reset is raised in two cases: the count reaches the selected span while the watchdog runs, or a key fault has waited out its fixed delay. The reset comes out as a one-cycle pulse. It also sets a sticky cause flag, which only an explicit clear drops. The pulse also returns the control byte to its power-on value, as the chip-wide reset it stands for would do.

Top module: `kwdt_top`

## Requirements
- R1: After reset, `ctrl_q` reads 8'h53 (key 01010, select 011), and `wdt_rst` and `rst_flag` are low.
- R2: When `wr_en` is high at a clock edge, the byte on `wr_data` is stored, and `ctrl_q` shows it from the next cycle on.
- R3: While the key field `ctrl_q[7:3]` is 10101, the count is held at zero and `wdt_rst` never pulses, however many ticks arrive.
- R4: While the key is 01010, the select field `ctrl_q[2:0]` sets the span N = 2^(BASE_EXP+k), with k = 0,2,4,6,7,8,9,10 for codes 000 to 111. `wdt_rst` is high for exactly one cycle, right after the edge that takes the N-th tick since the last clear.
- R5: A `kick` pulse restarts the count from zero. The next timeout then falls N ticks after the kick edge.
- R6: Any register write restarts the count from zero.
- R7: When the key field holds a value other than 01010 or 10101, `wdt_rst` pulses for one cycle on the (DELAY+1)-th rising edge after the edge that stored the value.
- R8: Writing a valid key while a fault reset is pending does not cancel it or move it.
- R9: Every `wdt_rst` pulse comes with `ctrl_q` back at 8'h53 and the count back at zero.
- R10: `rst_flag` goes high together with every `wdt_rst` pulse and then stays high. `flag_clr` drops it, except in a cycle that raises a new reset, where the new reset wins.
- R11: Only edges where `wd_tick` is high advance the count. Cycles without a tick leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_tick | input | 1 | One-cycle enable per watchdog clock period |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| kick | input | 1 | Software clear of the count |
| flag_clr | input | 1 | Clears the sticky reset flag |
| ctrl_q | output | 8 | Control byte readback |
| wdt_rst | output | 1 | One-cycle watchdog reset request |
| rst_flag | output | 1 | Sticky reset-cause flag |

## Verification
The bench builds the block with BASE_EXP=2 and DELAY=3. This shrinks the eight spans to 4 through 4096 ticks, so every select code can be run to its exact timeout edge in one short run. With the short delay, a valid key can be written inside the pending-fault window and the fixed firing edge checked. With the tick gated to alternate cycles, the bench shows that only tick edges count.

// File: rtl/kwdt_pkg.sv
// Shared constants for the keyed watchdog.
// Assumes a 5-bit key in the top of the control byte and a 3-bit select below it.
package kwdt_pkg;
    localparam logic [4:0] KEY_RUN  = 5'b01010;
    localparam logic [4:0] KEY_STOP = 5'b10101;
    localparam logic [7:0] CTRL_POR = 8'h53;
    localparam int unsigned SPAN_RANGE = 10;

    // Exponent offset above the base for each select code.
    function automatic int unsigned sel_offset(input logic [2:0] s);
        case (s)
            3'd0:    sel_offset = 0;
            3'd1:    sel_offset = 2;
            3'd2:    sel_offset = 4;
            3'd3:    sel_offset = 6;
            3'd4:    sel_offset = 7;
            3'd5:    sel_offset = 8;
            3'd6:    sel_offset = 9;
            default: sel_offset = 10;
        endcase
    endfunction
endpackage

// File: rtl/kwdt_ctrl_reg.sv
// Control byte storage and key decode.
// A restore request returns the byte to its power-on value and takes
// priority over a write in the same cycle. The key is decoded from the
// stored byte on every cycle, so an upset flop is seen as a fault too.
module kwdt_ctrl_reg
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       restore,
    output logic [7:0] ctrl_q,
    output logic       key_bad,
    output logic       run_en,
    output logic [2:0] sel
);
    logic [7:0] ctrl_r;
    logic [4:0] key;

    // Hold the control byte: reset or restore to the power-on value, else take writes.
    always_ff @(posedge clk) begin
        if (!rst_n || restore)
            ctrl_r <= CTRL_POR;
        else if (wr_en)
            ctrl_r <= wr_data;
    end

    // Split the stored byte into key and select and classify the key.
    always_comb begin
        key     = ctrl_r[7:3];
        sel     = ctrl_r[2:0];
        key_bad = (key != KEY_RUN) && (key != KEY_STOP);
        run_en  = (key != KEY_STOP);
    end

    assign ctrl_q = ctrl_r;
endmodule

// File: rtl/kwdt_count.sv
// Timeout counter.
// It counts tick enables from zero and raises hit on the tick that completes
// 2^(BASE_EXP+offset) ticks. It is held at zero while stopped and cleared by
// clr. Assumes BASE_EXP >= 1, so a span is never a single tick.
module kwdt_count
    import kwdt_pkg::*;
#(
    parameter int unsigned BASE_EXP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       clr,
    input  logic [2:0] sel,
    output logic       hit
);
    localparam int unsigned CNT_W = BASE_EXP + SPAN_RANGE;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;

    // Terminal count for the selected span.
    always_comb begin
        span = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + sel_offset(sel));
        lim  = span[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
        hit  = en && !clr && tick && (cnt_q == lim);
    end

    // Advance on ticks, wrap on the terminal tick, zero when stopped or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // R3
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/kwdt_fault_dly.sv
// Key-fault delay.
// A bad key arms a down-counter. fire is raised for one cycle when the
// count runs out, DELAY+1 edges after the bad key was stored. Once armed,
// the counter ignores the key until it fires. Assumes DELAY >= 1.
module kwdt_fault_dly #(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_bad,
    output logic fire
);
    localparam int unsigned DW = (DELAY < 2) ? 1 : $clog2(DELAY);

    logic          pend_q;
    logic [DW-1:0] dly_q;

    // Fire when the armed count has run out.
    assign fire = pend_q && (dly_q == '0);

    // Arm on a bad key, count down, disarm after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            dly_q  <= '0;
        end else if (!pend_q) begin
            if (key_bad) begin
                pend_q <= 1'b1;
                dly_q  <= DW'(DELAY - 1);
            end
        end else if (fire) begin
            pend_q <= 1'b0;
        end else begin
            dly_q <= dly_q - {{(DW-1){1'b0}}, 1'b1};
        end
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && dly_q != '0) |=> pend_q);
endmodule

// File: rtl/kwdt_top.sv
// Keyed-enable watchdog top.
// It joins the control byte, the timeout counter and the key-fault delay,
// and registers the reset pulse and the sticky cause flag. Assumes wd_tick
// is a one-cycle enable already in the clk domain.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned BASE_EXP = 8,
    parameter int unsigned DELAY    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       kick,
    input  logic       flag_clr,
    output logic [7:0] ctrl_q,
    output logic       wdt_rst,
    output logic       rst_flag
);
    logic       key_bad, run_en, fault_fire, cnt_hit, rst_req;
    logic [2:0] sel;
    logic       rst_q, flag_q;

    assign rst_req = fault_fire | cnt_hit;

    kwdt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .restore (rst_req),
        .ctrl_q  (ctrl_q),
        .key_bad (key_bad),
        .run_en  (run_en),
        .sel     (sel)
    );

    kwdt_count #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (wd_tick),
        .en    (run_en),
        .clr   (kick | wr_en | fault_fire),
        .sel   (sel),
        .hit   (cnt_hit)
    );

    kwdt_fault_dly #(.DELAY(DELAY)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_bad (key_bad),
        .fire    (fault_fire)
    );

    // Register the reset pulse and the sticky flag; a new reset beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            rst_q <= rst_req;
            if (rst_req)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign wdt_rst  = rst_q;
    assign rst_flag = flag_q;

    // R4
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    // R9
    restore_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (ctrl_q == CTRL_POR));

    // R10
    flag_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> rst_flag);
endmodule

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
module kwdt_top_tb;
    localparam int unsigned BASE = 2;
    localparam int unsigned DLY  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       kick = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] ctrl_q;
    logic       wdt_rst, rst_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    kwdt_top #(.BASE_EXP(BASE), .DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .wr_en(wr_en),
        .wr_data(wr_data), .kick(kick), .flag_clr(flag_clr),
        .ctrl_q(ctrl_q), .wdt_rst(wdt_rst), .rst_flag(rst_flag)
    );

    function automatic int unsigned span_of(input int unsigned s);
        int unsigned k[8] = '{0, 2, 4, 6, 7, 8, 9, 10};
        return 1 << (BASE + k[s]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    // n cycles with no reset pulse at all
    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst) seen = 1'b1;
        end
        chk(!seen, tag, seen, 0);
    endtask

    // pulse expected right after the next edge, then gone; byte restored
    task automatic expect_pulse(input string tag);
        @(negedge clk);
        chk(wdt_rst == 1'b1, tag, wdt_rst, 1);
        chk(ctrl_q == 8'h53, {tag, " R9 restore"}, ctrl_q, 8'h53);
        chk(rst_flag == 1'b1, {tag, " R10 flag"}, rst_flag, 1);
        @(negedge clk);
        chk(wdt_rst == 1'b0, {tag, " R4 one cycle"}, wdt_rst, 0);
    endtask

    task automatic t_reset();
        chk(ctrl_q == 8'h53, "R1 ctrl", ctrl_q, 8'h53);
        chk(wdt_rst == 1'b0, "R1 rst", wdt_rst, 0);
        chk(rst_flag == 1'b0, "R1 flag", rst_flag, 0);
    endtask

    task automatic t_write();
        write(8'h54);
        chk(ctrl_q == 8'h54, "R2 readback", ctrl_q, 8'h54);
    endtask

    task automatic t_all_spans();
        for (int s = 0; s < 8; s++) begin
            write({5'b01010, 3'(s)});
            quiet(span_of(s) - 1, "R4 early");
            expect_pulse("R4 span");
        end
    endtask

    task automatic t_stop();
        write(8'hA8);
        quiet(200, "R3 stopped");
        chk(ctrl_q == 8'hA8, "R3 byte kept", ctrl_q, 8'hA8);
        write(8'h50);
        quiet(3, "R3 restart early");
        expect_pulse("R3 restart");
    endtask

    task automatic t_kick();
        write(8'h51);
        quiet(10, "R5 before kick");
        do_kick();
        quiet(15, "R5 after kick");
        expect_pulse("R5 timeout");
    endtask

    task automatic t_rewrite();
        write(8'h52);
        quiet(30, "R6 before rewrite");
        write(8'h52);
        quiet(63, "R6 after rewrite");
        expect_pulse("R6 timeout");
    endtask

    task automatic t_fault();
        write(8'hFF);
        quiet(DLY, "R7 delay");
        expect_pulse("R7 fault");
    endtask

    task automatic t_fault_nocancel();
        write(8'h07);
        write(8'h53);
        quiet(DLY - 2, "R8 delay");
        expect_pulse("R8 still fires");
    endtask

    task automatic t_flag();
        quiet(5, "R10 idle");
        chk(rst_flag == 1'b1, "R10 sticky", rst_flag, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(rst_flag == 1'b0, "R10 cleared", rst_flag, 0);
    endtask

    task automatic t_gaps();
        wd_tick = 1'b0;
        write(8'h50);
        for (int i = 0; i < 4; i++) begin
            wd_tick = 1'b1;
            @(negedge clk);
            chk(wdt_rst == (i == 3), "R11 tick edge", wdt_rst, (i == 3));
            wd_tick = 1'b0;
            @(negedge clk);
            chk(wdt_rst == 1'b0, "R11 gap", wdt_rst, 0);
        end
        wd_tick = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_all_spans();
        t_flag();
        t_stop();
        t_kick();
        t_rewrite();
        t_fault();
        t_fault_nocancel();
        t_gaps();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule